// File: doc/BRIEF.md
# Pin-Change Interrupt Controller

This block watches a bank of input lines and records, per line, that the line has changed level since software last looked. Each line first passes through a short synchroniser. The synchronised value is then compared with its value one cycle earlier. Any difference, rising or falling, sets a sticky status bit for that line. The direction of the line and whoever owns it play no part in this.

Software selects which lines may raise the interrupt through a mask. It sets mask bits by writing ones to one word and clears them by writing ones to another. The mask only gates the interrupt output. Events on masked lines are still captured. A single active-high interrupt is raised while any captured event has its mask bit set.

Software learns which lines moved by reading the status word, and that read also clears it. An edge that lands in the same cycle as the clearing read is kept for the next read.

Top module: `pcic_top`

## Requirements
- R1: After reset, the status word at byte address 0x4C reads 0, the mask at 0x48 reads 0, and irq_o is low.
- R2: A rising level on line i sets status bit i. When the line changes just before rising clock edge k, the bit becomes visible at edge k+2 (with SYNC_STAGES=2) and not earlier.
- R3: A falling level on line i also sets status bit i. Several lines changing together set all their bits.
- R4: A read of 0x4C returns the captured bits, bit i for line i, and clears them. A second read with no new edges returns 0.
- R5: Writing to 0x44 ORs the ones of the write data into the mask. Zero bits leave the mask unchanged. The mask reads back at 0x48.
- R6: Writing to 0x40 clears the mask bits at the positions where the write data holds ones.
- R7: An edge on a line whose mask bit is 0 is still recorded in status but does not raise irq_o.
- R8: irq_o is high exactly when some line has both its status bit and its mask bit set. Setting the mask of a pending line raises irq_o one clock after the write. Clearing the status by a read lowers it.
- R9: An edge that is captured in the same clock edge as a clearing status read leaves its status bit set. The read itself returns the older bits.
- R10: A line held at a constant level from reset onward never produces a status bit, whatever that level is.
- R11: Writes to 0x48 or 0x4C change neither the mask nor the status, and do not clear the status. Reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | N_LINES | Monitored lines, one bit per line |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The checker enforces several properties on every cycle:
- A status bit never drops except through a status read, and a new bit only appears where the edge detector reported an event.
- A status read leaves behind only the events of its own cycle.
- The mask changes only through its set and clear words, and each of those moves exactly the written bits.
- irq_o is never high without a pending, unmasked line.

The directed scenarios cover what needs whole sequences of stimulus:
- the exact latency from a pin change to a visible status bit;
- the silence of lines held steady across reset;
- the race between a clearing read and an edge in the same cycle;
- the absence of effect from writes to the read-only words.

// File: rtl/pcic_pkg.sv
package pcic_pkg;
  // byte addresses of the register words
  localparam int unsigned OFS_MASK_CLR  = 32'h40;
  localparam int unsigned OFS_MASK_SET  = 32'h44;
  localparam int unsigned OFS_MASK_RD   = 32'h48;
  localparam int unsigned OFS_STATUS_RD = 32'h4C;
endpackage

// File: rtl/pcic_sync.sv
module pcic_sync #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] d_i,
  output logic [N_LINES-1:0] q_o
);
  logic [STAGES-1:0][N_LINES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/pcic_edge.sv
module pcic_edge #(
  parameter int unsigned N_LINES   = 32,
  parameter int unsigned PRIME_CYC = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] sync_i,
  output logic [N_LINES-1:0] event_o
);
  localparam int unsigned CNT_W = $clog2(PRIME_CYC + 1);

  logic [N_LINES-1:0] prev_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               primed;

  // edges are suppressed until the pipeline holds real samples
  assign primed = (cnt_q == CNT_W'(PRIME_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      cnt_q  <= '0;
    end else begin
      prev_q <= sync_i;
      if (!primed) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign event_o = primed ? (sync_i ^ prev_q) : '0;
endmodule

// File: rtl/pcic_status.sv
module pcic_status #(
  parameter int unsigned N_LINES = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] event_i,
  input  logic               clr_i,
  output logic [N_LINES-1:0] status_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_bit
    logic bit_q;
    // a new event wins over a clearing read in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         bit_q <= 1'b0;
      else if (event_i[i]) bit_q <= 1'b1;
      else if (clr_i)      bit_q <= 1'b0;
    end
    assign status_o[i] = bit_q;
  end
endmodule

// File: rtl/pcic_regif.sv
module pcic_regif
  import pcic_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  input  logic [N_LINES-1:0] status_i,
  output logic [N_LINES-1:0] mask_o,
  output logic               rd_status_o,
  output logic [DATA_W-1:0]  bus_rdata_o
);
  logic wr_en, rd_en;
  logic hit_clr, hit_set, hit_mask, hit_stat;
  logic [N_LINES-1:0] wbits;
  logic [N_LINES-1:0] mask_q;

  assign wr_en    = bus_sel_i &  bus_wr_i;
  assign rd_en    = bus_sel_i & ~bus_wr_i;
  assign hit_clr  = (bus_addr_i == ADDR_W'(OFS_MASK_CLR));
  assign hit_set  = (bus_addr_i == ADDR_W'(OFS_MASK_SET));
  assign hit_mask = (bus_addr_i == ADDR_W'(OFS_MASK_RD));
  assign hit_stat = (bus_addr_i == ADDR_W'(OFS_STATUS_RD));
  assign wbits    = bus_wdata_i[N_LINES-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                mask_q <= '0;
    else if (wr_en && hit_set)  mask_q <= mask_q | wbits;
    else if (wr_en && hit_clr)  mask_q <= mask_q & ~wbits;
  end

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en && hit_mask)      bus_rdata_o = DATA_W'(mask_q);
    else if (rd_en && hit_stat) bus_rdata_o = DATA_W'(status_i);
  end

  assign rd_status_o = rd_en & hit_stat;
  assign mask_o      = mask_q;
endmodule

// File: rtl/pcic_top.sv
module pcic_top #(
  parameter int unsigned N_LINES     = 32,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] line_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  localparam int unsigned PRIME_CYC = SYNC_STAGES + 1;

  logic [N_LINES-1:0] sync_w;
  logic [N_LINES-1:0] event_w;
  logic [N_LINES-1:0] status_w;
  logic [N_LINES-1:0] mask_w;
  logic               rd_status_w;

  pcic_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (line_i), .q_o (sync_w)
  );

  pcic_edge #(.N_LINES(N_LINES), .PRIME_CYC(PRIME_CYC)) u_edge (
    .clk_i (clk_i), .rst_ni (rst_ni), .sync_i (sync_w), .event_o (event_w)
  );

  pcic_status #(.N_LINES(N_LINES)) u_status (
    .clk_i (clk_i), .rst_ni (rst_ni), .event_i (event_w),
    .clr_i (rd_status_w), .status_o (status_w)
  );

  pcic_regif #(.N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .status_i    (status_w),
    .mask_o      (mask_w),
    .rd_status_o (rd_status_w),
    .bus_rdata_o (bus_rdata_o)
  );

  assign irq_o = |(status_w & mask_w);
endmodule

// File: rtl/pcic_chk.sv
module pcic_chk
  import pcic_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               bus_sel_i,
  input logic               bus_wr_i,
  input logic [ADDR_W-1:0]  bus_addr_i,
  input logic [DATA_W-1:0]  bus_wdata_i,
  input logic               irq_o,
  input logic [N_LINES-1:0] status_q,
  input logic [N_LINES-1:0] mask_q,
  input logic [N_LINES-1:0] event_w
);
  logic rd_st, set_m, clr_m;
  logic [N_LINES-1:0] wd;

  assign rd_st = bus_sel_i && !bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STATUS_RD));
  assign set_m = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(OFS_MASK_SET));
  assign clr_m = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(OFS_MASK_CLR));
  assign wd    = bus_wdata_i[N_LINES-1:0];

  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_st |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_read_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |=> ((status_q & ~$past(event_w)) == '0));

  p_set_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_q) |-> ((status_q & ~$past(status_q) & ~$past(event_w)) == '0));

  p_race_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |=> ((status_q & $past(event_w)) == $past(event_w)));

  p_mask_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_m |=> ((mask_q & $past(wd)) == $past(wd)));

  p_mask_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_m || clr_m) |=> $stable(mask_q));

  p_mask_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_m |=> ((mask_q & $past(wd)) == '0));

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((status_q & mask_q) != '0));
endmodule

bind pcic_top pcic_chk #(.N_LINES(N_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_sel_i   (bus_sel_i),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .irq_o       (irq_o),
  .status_q    (status_w),
  .mask_q      (mask_w),
  .event_w     (event_w)
);

// File: tb/sim_pcic_top.sv
`timescale 1ns/1ps
module sim_pcic_top;
  localparam int unsigned NL = 32;
  localparam logic [7:0] A_CLR  = 8'h40;
  localparam logic [7:0] A_SET  = 8'h44;
  localparam logic [7:0] A_MASK = 8'h48;
  localparam logic [7:0] A_STAT = 8'h4C;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] lines = 32'hA5A5_0F0F;
  logic          sel = 1'b0;
  logic          wr = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq;
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  pcic_top u0 (
    .clk_i (clk), .rst_ni (rst_n), .line_i (lines),
    .bus_sel_i (sel), .bus_wr_i (wr), .bus_addr_i (addr),
    .bus_wdata_i (wdata), .bus_rdata_o (rdata), .irq_o (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk); sel = 1'b0;
  endtask

  task automatic flip(input logic [31:0] m);
    @(negedge clk); lines = lines ^ m;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    #1 chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    bus_read(A_STAT, d); chk("R10 steady lines give no status", d, 32'h0);
    bus_read(A_MASK, d); chk("R1 mask reset", d, 32'h0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    bus_write(A_SET, 32'h10);
    flip(32'h10);
    @(negedge clk); chk("R2 not visible after one edge", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R2 not visible after two edges", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R2 visible after three edges", {31'b0, irq}, 32'h1);
    bus_read(A_STAT, d); chk("R4 read returns rising bit", d, 32'h10);
    bus_read(A_STAT, d); chk("R4 second read empty", d, 32'h0);
    chk("R8 irq low once cleared", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_fall();
    logic [31:0] d;
    flip(32'h1);
    settle();
    chk("R7 masked line raises no irq", {31'b0, irq}, 32'h0);
    bus_read(A_STAT, d); chk("R3 R7 falling edge recorded", d, 32'h1);
    flip(32'hFFFF_0000);
    settle();
    bus_read(A_STAT, d); chk("R3 many lines at once", d, 32'hFFFF_0000);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    bus_write(A_SET, 32'hF0);
    bus_read(A_MASK, d); chk("R5 mask set ORs bits", d, 32'hF0);
    bus_write(A_SET, 32'h0);
    bus_read(A_MASK, d); chk("R5 zero write leaves mask", d, 32'hF0);
    bus_write(A_CLR, 32'h30);
    bus_read(A_MASK, d); chk("R6 mask clear", d, 32'hC0);
    bus_write(A_CLR, 32'hFFFF_FFFF);
    bus_read(A_MASK, d); chk("R6 mask clear all", d, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    bus_write(A_SET, 32'h100);
    flip(32'h200);
    settle();
    chk("R8 unmasked line pending, masked other", {31'b0, irq}, 32'h0);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = A_SET; wdata = 32'h200;
    @(negedge clk); sel = 1'b0; wr = 1'b0;
    chk("R8 irq one edge after mask set", {31'b0, irq}, 32'h1);
    bus_read(A_STAT, d); chk("R8 pending bit read", d, 32'h200);
    chk("R8 irq drops after read", {31'b0, irq}, 32'h0);
    bus_write(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic t_race();
    logic [31:0] d;
    flip(32'h2);
    settle();
    flip(32'h4);
    @(negedge clk);
    bus_read(A_STAT, d); chk("R9 read returns older bits", d, 32'h2);
    bus_read(A_STAT, d); chk("R9 same-cycle edge kept", d, 32'h4);
  endtask

  task automatic t_bus();
    logic [31:0] d;
    bus_write(A_SET, 32'h8);
    flip(32'h20);
    settle();
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_write(A_MASK, 32'hFFFF_FFFF);
    bus_read(A_MASK, d); chk("R11 mask unchanged by read-only writes", d, 32'h8);
    bus_read(A_STAT, d); chk("R11 status not cleared by write", d, 32'h20);
    bus_read(8'h50, d); chk("R11 unmapped read zero", d, 32'h0);
    bus_read(A_CLR, d); chk("R11 write-only word reads zero", d, 32'h0);
  endtask

  initial begin
    t_reset();
    t_rise();
    t_fall();
    t_mask();
    t_irq();
    t_race();
    t_bus();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule